// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block decides which of five interrupt sources a small 8-bit microcontroller core should service next. The sources are two active-low external pins, two timer overflow flags and a serial port event (transmit done or receive done). The block holds three 8-bit control registers: an enable mask with a master bit, a per-source priority mask and a trigger-type register for the external pins. The core loads these through a simple write port.

The block keeps a registered interrupt request and a 3-bit source index. When the core fetches the vector, it pulses an acknowledge. The controller then moves its in-service state up to the priority of the accepted source and saves the state it left. A return pulse restores the saved state. In the in-service state, a high-priority routine can preempt a low-priority one. Equal or lower requests are held off until the running routine returns. Each external pin can be level- or edge-triggered. An edge capture stays pending until that source is acknowledged.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_req` is 0, `isr_level` is 00 and all three control registers are zero. With every source active, no request is raised.
- R2: `cfg_we` writes `cfg_wdata` into one register, chosen by `cfg_sel`: 0 = enable, 1 = priority, 2 = trigger. In the enable register, bit 7 is the master enable. Bits 0 to 4 enable external 0, timer 0, external 1, timer 1 and serial. A source counts only when the master bit and its own bit are both 1.
- R3: Priority-register bits 0 to 4 map to the sources in the same order as the enable bits. A 1 selects high priority. A high-priority request beats any low-priority one. Within one priority level, the lowest index wins. `irq_idx` is 0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1, 4 = serial.
- R4: The serial source requests service when `ser_tx_done` or `ser_rx_done` is 1.
- R5: `isr_level` encodes 00 = idle, 01 = low-priority routine, 11 = high-priority routine, and never takes the value 10. In state 00 any enabled request is raised. An accepted acknowledge moves the state to 01 for a low-priority source or to 11 for a high-priority source. Without an acknowledge or a return, the state does not change.
- R6: In state 01, only high-priority requests are raised. A pending low-priority request stays held off until a return brings the state back to 00.
- R7: In state 11, no request is raised.
- R8: A return pulse restores the state saved at the matching acknowledge. A return pulse in state 00 is ignored.
- R9: Trigger-register bit 0 sets the mode for external 0, and bit 2 sets it for external 1. A 1 selects falling-edge mode and a 0 selects low-level mode on the active-low pin.
- R10: In edge mode, a captured falling edge stays pending even after the pin goes high again. It is cleared only by an acknowledge of that source. A pin held low after that acknowledge raises no new request.
- R11: Pins are sampled only on cycles with `cyc_tick` = 1. In level mode the request is not latched, so raising the pin before acknowledge withdraws it.
- R12: `irq_req` and `irq_idx` are registered. An acknowledge counts only while `irq_req` is 1 and `irq_ret` is 0. After an accepted acknowledge, `irq_req` is 0 on the next cycle. An acknowledge while `irq_req` is 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_tick | input | 1 | Machine-cycle strobe that gates pin sampling |
| cfg_we | input | 1 | Control register write strobe |
| cfg_sel | input | 2 | Register select: 0 enable, 1 priority, 2 trigger |
| cfg_wdata | input | 8 | Write data |
| ext_n | input | 2 | Active-low external pins (bit 0 = external 0) |
| tmr_ovf | input | 2 | Timer overflow flags (bit 0 = timer 0) |
| ser_tx_done | input | 1 | Serial transmit-done flag |
| ser_rx_done | input | 1 | Serial receive-done flag |
| irq_ack | input | 1 | Vector fetch acknowledge |
| irq_ret | input | 1 | Return from interrupt |
| irq_req | output | 1 | Interrupt request to the core |
| irq_idx | output | 3 | Winning source index |
| isr_level | output | 2 | Current in-service state |

## Verification
A vector table applies mixes of active sources under varied enable and priority masks while the state is idle. It tells apart masking by the master bit, masking by a source bit, a high-priority win over a lower index, and the fixed order within one level. Directed sequences then nest two acknowledges. They show a high-priority timer preempting a low-priority one, and the low-priority source held until the final return. Holding an external pin low in edge mode and in level mode, around an acknowledge and return, gives no repeat request in edge mode and a repeat request in level mode. Short pulses, pin releases and a stalled `cyc_tick` separate edge latching from level withdrawal and from sampling.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC = 5;
  localparam int IDX_W   = 3;
  localparam int CFG_W   = 8;
  localparam int MASTER_BIT = 7;

  typedef enum logic [1:0] {
    LVL_IDLE = 2'b00,
    LVL_LOW  = 2'b01,
    LVL_HIGH = 2'b11
  } isr_lvl_e;

  typedef enum logic [1:0] {
    SEL_ENABLE  = 2'd0,
    SEL_PRIO    = 2'd1,
    SEL_TRIGGER = 2'd2
  } cfg_sel_e;
endpackage

// File: rtl/irq_ext_detect.sv
module irq_ext_detect #(
  parameter int NUM_EXT = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [NUM_EXT-1:0] pin_n,
  input  logic [NUM_EXT-1:0] edge_mode,
  input  logic [NUM_EXT-1:0] clr,
  output logic [NUM_EXT-1:0] req
);
  logic [NUM_EXT-1:0] pin_s;
  logic [NUM_EXT-1:0] edge_q;

  for (genvar g = 0; g < NUM_EXT; g++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        pin_s[g]  <= 1'b1;
        edge_q[g] <= 1'b0;
      end else begin
        if (tick) pin_s[g] <= pin_n[g];
        if (!edge_mode[g])
          edge_q[g] <= 1'b0;
        else if (tick && pin_s[g] && !pin_n[g])
          edge_q[g] <= 1'b1;
        else if (clr[g])
          edge_q[g] <= 1'b0;
      end
    end
    assign req[g] = edge_mode[g] ? edge_q[g] : ~pin_s[g];
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_pkg::*;
#(
  parameter int N = NUM_SRC,
  parameter int W = IDX_W
) (
  input  logic [N-1:0] src,
  input  logic [N-1:0] mask,
  input  logic [N-1:0] pri,
  input  logic [1:0]   level,
  output logic         any,
  output logic [W-1:0] win
);
  logic [N-1:0] elig;
  logic         hi_any, lo_any;
  logic [W-1:0] hi_idx, lo_idx;

  for (genvar g = 0; g < N; g++) begin : g_elig
    always_comb begin
      unique case (level)
        LVL_IDLE: elig[g] = src[g] & mask[g];
        LVL_LOW:  elig[g] = src[g] & mask[g] & pri[g];
        default:  elig[g] = 1'b0;
      endcase
    end
  end

  always_comb begin
    hi_any = 1'b0;
    lo_any = 1'b0;
    hi_idx = '0;
    lo_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i] && pri[i]) begin
        hi_any = 1'b1;
        hi_idx = W'(i);
      end
      if (elig[i] && !pri[i]) begin
        lo_any = 1'b1;
        lo_idx = W'(i);
      end
    end
    any = hi_any | lo_any;
    win = hi_any ? hi_idx : lo_idx;
  end
endmodule

// File: rtl/irq_nest.sv
module irq_nest
  import irq_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       push,
  input  logic [1:0] push_lvl,
  input  logic       pop,
  output logic [1:0] level
);
  localparam int SP_W    = $clog2(DEPTH + 1);
  localparam int SLOTS   = 1 << SP_W;

  logic [1:0]      stack_q [SLOTS];
  logic [SP_W-1:0] sp_q;
  logic [1:0]      level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q    <= '0;
      level_q <= LVL_IDLE;
      for (int i = 0; i < SLOTS; i++) stack_q[i] <= LVL_IDLE;
    end else if (pop) begin
      if (sp_q != '0) begin
        level_q <= stack_q[sp_q - 1'b1];
        sp_q    <= sp_q - 1'b1;
      end
    end else if (push && (int'(sp_q) < DEPTH)) begin
      stack_q[sp_q] <= level_q;
      sp_q          <= sp_q + 1'b1;
      level_q       <= push_lvl;
    end
  end

  assign level = level_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int NEST_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_tick,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic [1:0]       ext_n,
  input  logic [1:0]       tmr_ovf,
  input  logic             ser_tx_done,
  input  logic             ser_rx_done,
  input  logic             irq_ack,
  input  logic             irq_ret,
  output logic             irq_req,
  output logic [IDX_W-1:0] irq_idx,
  output logic [1:0]       isr_level
);
  logic [CFG_W-1:0]   en_q, pri_q, trig_q;
  logic [1:0]         ext_req, ext_clr, edge_mode;
  logic [NUM_SRC-1:0] src, mask;
  logic               any;
  logic [IDX_W-1:0]   win;
  logic               req_q;
  logic [IDX_W-1:0]   idx_q;
  logic               ack_ok;
  logic [1:0]         lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pri_q  <= '0;
      trig_q <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_ENABLE:  en_q   <= cfg_wdata;
        SEL_PRIO:    pri_q  <= cfg_wdata;
        SEL_TRIGGER: trig_q <= cfg_wdata;
        default: ;
      endcase
    end
  end

  assign ack_ok    = irq_ack & req_q & ~irq_ret;
  assign edge_mode = {trig_q[2], trig_q[0]};
  assign ext_clr   = {ack_ok && (idx_q == IDX_W'(2)), ack_ok && (idx_q == IDX_W'(0))};

  irq_ext_detect #(.NUM_EXT(2)) u_ext (
    .clk(clk), .rst(rst), .tick(cyc_tick), .pin_n(ext_n),
    .edge_mode(edge_mode), .clr(ext_clr), .req(ext_req)
  );

  assign src  = {ser_tx_done | ser_rx_done, tmr_ovf[1], ext_req[1], tmr_ovf[0], ext_req[0]};
  assign mask = en_q[MASTER_BIT] ? en_q[NUM_SRC-1:0] : '0;

  irq_pick #(.N(NUM_SRC), .W(IDX_W)) u_pick (
    .src(src), .mask(mask), .pri(pri_q[NUM_SRC-1:0]), .level(lvl),
    .any(any), .win(win)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      idx_q <= '0;
    end else begin
      req_q <= any & ~ack_ok;
      idx_q <= win;
    end
  end

  irq_nest #(.DEPTH(NEST_DEPTH)) u_nest (
    .clk(clk), .rst(rst), .push(ack_ok),
    .push_lvl(pri_q[idx_q] ? LVL_HIGH : LVL_LOW),
    .pop(irq_ret), .level(lvl)
  );

  assign irq_req   = req_q;
  assign irq_idx   = idx_q;
  assign isr_level = lvl;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       irq_ack,
  input logic       irq_ret,
  input logic       irq_req,
  input logic [2:0] irq_idx,
  input logic [1:0] isr_level
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!irq_req && isr_level == 2'b00)); // R1
  AST_LEVEL_CODE: assert property (@(posedge clk) disable iff (rst) isr_level != 2'b10); // R5
  AST_ACK_RAISES: assert property (@(posedge clk) disable iff (rst) (irq_ack && irq_req && !irq_ret) |=> isr_level != $past(isr_level)); // R5
  AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (rst) (!irq_ack && !irq_ret) |=> $stable(isr_level)); // R5
  AST_TOP_BLOCKS: assert property (@(posedge clk) disable iff (rst) isr_level == 2'b11 |-> !irq_req); // R7
  AST_RET_NO_RISE: assert property (@(posedge clk) disable iff (rst) irq_ret |=> isr_level <= $past(isr_level)); // R8
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst) irq_req |-> irq_idx <= 3'd4); // R3
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst) (irq_ack && irq_req && !irq_ret) |=> !irq_req); // R12
endmodule

bind prio_irq_ctrl irq_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .irq_ack(irq_ack), .irq_ret(irq_ret),
  .irq_req(irq_req), .irq_idx(irq_idx), .isr_level(isr_level)
);

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/100ps
module tb_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc_tick = 1'b1;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [1:0] ext_n = 2'b11;
  logic [1:0] tmr_ovf = 2'b00;
  logic       ser_tx_done = 1'b0;
  logic       ser_rx_done = 1'b0;
  logic       irq_ack = 1'b0;
  logic       irq_ret = 1'b0;
  logic       irq_req;
  logic [2:0] irq_idx;
  logic [1:0] isr_level;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl dut (
    .clk(clk), .rst(rst), .cyc_tick(cyc_tick), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ext_n(ext_n), .tmr_ovf(tmr_ovf), .ser_tx_done(ser_tx_done),
    .ser_rx_done(ser_rx_done), .irq_ack(irq_ack), .irq_ret(irq_ret),
    .irq_req(irq_req), .irq_idx(irq_idx), .isr_level(isr_level)
  );

  // {en, pri, ext_n, tmr_ovf, {tx,rx}, exp_req, exp_idx}; level-mode pins, idle state
  localparam logic [25:0] VEC [11] = '{
    {8'h00, 8'h00, 2'b00, 2'b11, 2'b11, 1'b0, 3'd0},
    {8'h9F, 8'h00, 2'b00, 2'b11, 2'b11, 1'b1, 3'd0},
    {8'h9F, 8'h10, 2'b00, 2'b11, 2'b11, 1'b1, 3'd4},
    {8'h9F, 8'h0A, 2'b00, 2'b11, 2'b11, 1'b1, 3'd1},
    {8'h9E, 8'h00, 2'b00, 2'b11, 2'b11, 1'b1, 3'd1},
    {8'h9F, 8'h00, 2'b11, 2'b10, 2'b01, 1'b1, 3'd3},
    {8'h9F, 8'h00, 2'b11, 2'b00, 2'b10, 1'b1, 3'd4},
    {8'h1F, 8'h00, 2'b00, 2'b11, 2'b11, 1'b0, 3'd0},
    {8'h9F, 8'h00, 2'b01, 2'b00, 2'b00, 1'b1, 3'd2},
    {8'h9F, 8'h14, 2'b00, 2'b11, 2'b11, 1'b1, 3'd2},
    {8'h9F, 8'h00, 2'b11, 2'b00, 2'b00, 1'b0, 3'd0}
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    cyc(1);
    cfg_we = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1; cyc(1); irq_ack = 1'b0;
  endtask

  task automatic ret();
    irq_ret = 1'b1; cyc(1); irq_ret = 1'b0;
  endtask

  task automatic chk(input string tag, input logic er, input logic [2:0] ei, input logic [1:0] el);
    n_chk++;
    if (irq_req !== er || (er && irq_idx !== ei) || isr_level !== el) begin
      n_fail++;
      $display("FAIL %s: req/idx/lvl actual %b/%0d/%b expected %b/%0d/%b",
               tag, irq_req, irq_idx, isr_level, er, ei, el);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    tmr_ovf = 2'b11; ser_tx_done = 1'b1; ext_n = 2'b00;
    cyc(4); rst = 1'b0; cyc(3);
    chk("R1 reset idle, all masked", 1'b0, 3'd0, 2'b00);
    tmr_ovf = 2'b00; ser_tx_done = 1'b0; ext_n = 2'b11;

    // R2 R3 R4 table walk
    for (int i = 0; i < 11; i++) begin
      wr(2'd0, VEC[i][25:18]);
      wr(2'd1, VEC[i][17:10]);
      wr(2'd2, 8'h00);
      ext_n = VEC[i][9:8]; tmr_ovf = VEC[i][7:6];
      ser_tx_done = VEC[i][5]; ser_rx_done = VEC[i][4];
      cyc(3);
      chk($sformatf("R2/R3/R4 vector %0d", i), VEC[i][3], VEC[i][2:0], 2'b00);
    end
    ext_n = 2'b11; tmr_ovf = 2'b00; ser_tx_done = 1'b0; ser_rx_done = 1'b0;

    // Preemption: timer1 high priority, timer0 low
    wr(2'd0, 8'h9F); wr(2'd1, 8'h08); cyc(3);
    tmr_ovf = 2'b01; cyc(3);
    chk("R5 low request raised", 1'b1, 3'd1, 2'b00);
    ack();
    chk("R12 req drops after ack, R5 low state", 1'b0, 3'd0, 2'b01);
    cyc(3);
    chk("R6 low request held off", 1'b0, 3'd0, 2'b01);
    tmr_ovf = 2'b11; cyc(3);
    chk("R6 high preempts low routine", 1'b1, 3'd3, 2'b01);
    ack(); cyc(3);
    chk("R7 nothing accepted in high state", 1'b0, 3'd0, 2'b11);
    tmr_ovf = 2'b01; ret(); cyc(3);
    chk("R8 return restores low state", 1'b0, 3'd0, 2'b01);
    ret(); cyc(3);
    chk("R8 return to idle releases held request", 1'b1, 3'd1, 2'b00);
    tmr_ovf = 2'b00; cyc(3);
    ret(); cyc(1);
    chk("R8 return at idle ignored", 1'b0, 3'd0, 2'b00);
    ack(); cyc(1);
    chk("R12 ack without request ignored", 1'b0, 3'd0, 2'b00);

    // Edge vs level with pin held low
    wr(2'd0, 8'h85); wr(2'd1, 8'h00); wr(2'd2, 8'h01); cyc(3);
    ext_n = 2'b10; cyc(3);
    chk("R9 edge request on falling pin", 1'b1, 3'd0, 2'b00);
    ack(); ret(); cyc(3);
    chk("R10 edge held low no repeat", 1'b0, 3'd0, 2'b00);
    ext_n = 2'b00; cyc(3);
    chk("R9 level pin low requests", 1'b1, 3'd2, 2'b00);
    ack(); ret(); cyc(3);
    chk("R9 level held low repeats", 1'b1, 3'd2, 2'b00);
    ext_n = 2'b11; cyc(3);
    chk("R11 level withdrawn on release", 1'b0, 3'd0, 2'b00);

    // Edge pulse stays latched
    ext_n = 2'b10; cyc(1); ext_n = 2'b11; cyc(3);
    chk("R10 edge pulse stays pending", 1'b1, 3'd0, 2'b00);
    ack(); ret(); cyc(3);
    chk("R10 ack clears edge capture", 1'b0, 3'd0, 2'b00);

    // Sampling gated by cyc_tick
    cyc_tick = 1'b0; ext_n = 2'b01; cyc(3);
    chk("R11 no sample without tick", 1'b0, 3'd0, 2'b00);
    cyc_tick = 1'b1; cyc(3);
    chk("R11 sampled on tick", 1'b1, 3'd2, 2'b00);
    ext_n = 2'b11; cyc(3);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule